// File: doc/BRIEF.md
# Multi-Sector NOR Flash Erase Sequencer

This block erases a contiguous range of uniform sectors in a byte-wide parallel NOR flash. It acts as the bus master toward the flash. A start pulse captures the first and last sector index, a protect bitmap with one bit per sector, the sector size as a shift amount, and an erase timeout in clock cycles. The block sends the five-write unlock and erase-setup preamble once. It then queues one sector-erase command for each unprotected sector in the range and skips the protected ones.

After the last command the block stays off the bus for a fixed minimum settle time. It then reads the start of the last sector it started until bit 7 reads 1. A clean finish puts the flash back into read mode. The block reports a status code and the number of protected sectors it skipped. Every flash access uses a simple request/acknowledge handshake: the request and its address, data and direction stay steady until the acknowledge. Read data is taken in the acknowledge cycle.

Top module: `nor_erase_seq`

## Requirements
- R1: A range with a negative first index, a negative last index, a last index at or beyond the sector count, or first greater than last is rejected. `done` pulses one cycle after `start` with status 2 and skipped 0, and no bus request is raised. Indices are two's complement, and the top bit is the sign.
- R2: An accepted range begins with exactly five writes, each relative to `BASE_ADDR`: 0xAA at +0x555, 0x55 at +0x2AA, 0x80 at +0x555, 0xAA at +0x555, 0x55 at +0x2AA.
- R3: For each index from first to last in ascending order whose protect bit is 0, one write of 0x30 goes to `BASE_ADDR + (index << sect_shift)`.
- R4: No write is issued for a protected index in the range. `skipped` reports how many protected indices the range held.
- R5: After the acknowledge of the last sector-erase write, the first poll request comes no earlier than `WAIT_CYC` cycles later.
- R6: Polling reads (`we`=0) target the start address of the last sector started. They repeat until a read returns bit 7 = 1.
- R7: If a poll read returns bit 7 = 0 once `tout_cycles` cycles have passed in polling, the operation ends with status 1 and no read-mode write.
- R8: If every sector in the range is protected, no poll read takes place. The preamble is followed directly by the read-mode write.
- R9: A completed erase ends with a write of 0xF0 to `BASE_ADDR`, then a one-cycle `done` pulse with status 0. `busy` is low after `done`.
- R10: While `req` is high and `ack` is low, `req`, `we`, `addr` and `wdata` hold their values.
- R11: A `start` pulse while `busy` is high is ignored, and the operation in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an erase with the operands below |
| first_sect | input | IW+1 | First sector index, two's complement |
| last_sect | input | IW+1 | Last sector index, two's complement |
| protect | input | NSECT | Protect bitmap, bit i guards sector i |
| sect_shift | input | SHW | log2 of the sector size in bytes |
| tout_cycles | input | TW | Polling timeout in clock cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 bad range |
| skipped | output | IW+1 | Protected sectors skipped in the last operation |
| req | output | 1 | Bus request |
| we | output | 1 | 1 write, 0 read |
| addr | output | AW | Byte address |
| wdata | output | 8 | Write data |
| ack | input | 1 | Bus acknowledge, one cycle per request |
| rdata | input | 8 | Read data, valid with `ack` |

## Verification
A wrong sector cursor or a wrong protect lookup shows up on the bus right away. The sector-erase write goes to the wrong address, or a protected sector receives 0x30, and the full per-operation access log catches this at the next erase write. A wrong last-started register makes the poll reads hit a different address, which the first poll read exposes. A settle or timeout counter that is off shows as a gap that is too short before polling, or as a status that is wrong or comes too early. Both are measured in cycles against the acknowledge timestamps of the slave model.

// File: rtl/nes_pkg.sv
package nes_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_SCAN, S_ERASE, S_WAIT, S_POLL, S_RESET
  } nes_state_t;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_TOUT  = 2'd1;
  localparam logic [1:0] ST_RANGE = 2'd2;

  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_READ  = 8'hF0;
  localparam int         SETUP_LEN = 5;
endpackage

// File: rtl/nes_setup_rom.sv
module nes_setup_rom (
  input  logic [2:0]  step,
  output logic [11:0] off,
  output logic [7:0]  data
);
  always_comb begin
    case (step)
      3'd0:    begin off = 12'h555; data = 8'hAA; end
      3'd1:    begin off = 12'h2AA; data = 8'h55; end
      3'd2:    begin off = 12'h555; data = 8'h80; end
      3'd3:    begin off = 12'h555; data = 8'hAA; end
      default: begin off = 12'h2AA; data = 8'h55; end
    endcase
  end
endmodule

// File: rtl/nes_range_chk.sv
module nes_range_chk #(
  parameter int NSECT = 64,
  parameter int IW    = 6
) (
  input  logic [IW:0] first_i,
  input  logic [IW:0] last_i,
  output logic        ok
);
  localparam logic [IW:0] LIMIT = (IW+1)'(NSECT);

  always_comb begin
    ok = !first_i[IW] && !last_i[IW] && (last_i < LIMIT) && (first_i <= last_i);
  end
endmodule

// File: rtl/nes_timer.sv
module nes_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en && cnt != TOP)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nes_pkg::*;
#(
  parameter int          NSECT     = 64,
  parameter int          AW        = 22,
  parameter int          SHW       = 5,
  parameter int          TW        = 24,
  parameter int          WAIT_CYC  = 200000,
  parameter logic [21:0] BASE_ADDR = 22'h0,
  localparam int         IW        = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IW:0]      first_sect,
  input  logic [IW:0]      last_sect,
  input  logic [NSECT-1:0] protect,
  input  logic [SHW-1:0]   sect_shift,
  input  logic [TW-1:0]    tout_cycles,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status,
  output logic [IW:0]      skipped,
  output logic             req,
  output logic             we,
  output logic [AW-1:0]    addr,
  output logic [7:0]       wdata,
  input  logic             ack,
  input  logic [7:0]       rdata
);
  localparam int          WW   = $clog2(WAIT_CYC + 1);
  localparam logic [WW-1:0] WLIM = WW'(WAIT_CYC);
  localparam logic [AW-1:0] BASE = AW'(BASE_ADDR);
  localparam logic [IW:0]   ONE  = (IW+1)'(1);

  nes_state_t       state;
  logic [IW:0]      first_q, last_q, cur;
  logic [IW-1:0]    last_s;
  logic [NSECT-1:0] prot_q;
  logic [SHW-1:0]   shift_q;
  logic [TW-1:0]    tout_q;
  logic [2:0]       step;
  logic             any_started;

  logic             rng_ok;
  logic [11:0]      rom_off;
  logic [7:0]       rom_data;
  logic [WW-1:0]    wait_cnt;
  logic [TW-1:0]    poll_cnt;
  logic [IW-1:0]    cur_idx;
  logic [AW-1:0]    cur_addr, last_addr;
  logic             unused_rbits;

  assign cur_idx      = cur[IW-1:0];
  assign cur_addr     = BASE + (AW'(cur_idx) << shift_q);
  assign last_addr    = BASE + (AW'(last_s) << shift_q);
  assign unused_rbits = ^rdata[6:0];

  nes_range_chk #(.NSECT(NSECT), .IW(IW)) u_rng (
    .first_i (first_sect),
    .last_i  (last_sect),
    .ok      (rng_ok)
  );

  nes_setup_rom u_rom (
    .step (step),
    .off  (rom_off),
    .data (rom_data)
  );

  nes_timer #(.W(WW)) u_wait (
    .clk (clk),
    .rst (rst),
    .clr (state != S_WAIT),
    .en  (state == S_WAIT),
    .cnt (wait_cnt)
  );

  nes_timer #(.W(TW)) u_poll (
    .clk (clk),
    .rst (rst),
    .clr (state != S_POLL),
    .en  (state == S_POLL),
    .cnt (poll_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      busy        <= 1'b0;
      done        <= 1'b0;
      status      <= ST_OK;
      skipped     <= '0;
      req         <= 1'b0;
      we          <= 1'b0;
      addr        <= '0;
      wdata       <= '0;
      first_q     <= '0;
      last_q      <= '0;
      cur         <= '0;
      last_s      <= '0;
      prot_q      <= '0;
      shift_q     <= '0;
      tout_q      <= '0;
      step        <= '0;
      any_started <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            skipped     <= '0;
            first_q     <= first_sect;
            last_q      <= last_sect;
            prot_q      <= protect;
            shift_q     <= sect_shift;
            tout_q      <= tout_cycles;
            any_started <= 1'b0;
            step        <= '0;
            if (!rng_ok) begin
              done   <= 1'b1;
              status <= ST_RANGE;
            end else begin
              busy  <= 1'b1;
              state <= S_SETUP;
            end
          end
        end
        S_SETUP: begin
          if (!req) begin
            req   <= 1'b1;
            we    <= 1'b1;
            addr  <= BASE + AW'(rom_off);
            wdata <= rom_data;
          end else if (ack) begin
            req <= 1'b0;
            if (step == 3'(SETUP_LEN - 1)) begin
              state <= S_SCAN;
              cur   <= first_q;
            end else begin
              step <= step + 1'b1;
            end
          end
        end
        S_SCAN: begin
          if (cur > last_q) begin
            state <= any_started ? S_WAIT : S_RESET;
          end else if (prot_q[cur_idx]) begin
            skipped <= skipped + ONE;
            cur     <= cur + ONE;
          end else begin
            state <= S_ERASE;
          end
        end
        S_ERASE: begin
          if (!req) begin
            req   <= 1'b1;
            we    <= 1'b1;
            addr  <= cur_addr;
            wdata <= CMD_SECT;
          end else if (ack) begin
            req         <= 1'b0;
            last_s      <= cur_idx;
            any_started <= 1'b1;
            cur         <= cur + ONE;
            state       <= S_SCAN;
          end
        end
        S_WAIT: begin
          if (wait_cnt >= WLIM) state <= S_POLL;
        end
        S_POLL: begin
          if (!req) begin
            req  <= 1'b1;
            we   <= 1'b0;
            addr <= last_addr;
          end else if (ack) begin
            req <= 1'b0;
            if (rdata[7]) begin
              state <= S_RESET;
            end else if (poll_cnt >= tout_q) begin
              status <= ST_TOUT;
              done   <= 1'b1;
              busy   <= 1'b0;
              state  <= S_IDLE;
            end
          end
        end
        S_RESET: begin
          if (!req) begin
            req   <= 1'b1;
            we    <= 1'b1;
            addr  <= BASE;
            wdata <= CMD_READ;
          end else if (ack) begin
            req    <= 1'b0;
            status <= ST_OK;
            done   <= 1'b1;
            busy   <= 1'b0;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req && !ack |=> req && $stable(addr) && $stable(we) && $stable(wdata));

  // R1
  bad_range_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_IDLE && start && !rng_ok |=> done && status == ST_RANGE && !req && !busy);

  // R4
  prot_skip_chk: assert property (@(posedge clk) disable iff (rst)
    req && we && state == S_ERASE |-> !prot_q[cur_idx] && wdata == CMD_SECT);

  // R7
  tout_noreset_chk: assert property (@(posedge clk) disable iff (rst)
    done && status == ST_TOUT |-> !we);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !req);

  // R11
  busy_state_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> state != S_IDLE);
endmodule

// File: tb/sim_nor_erase_seq.sv
module sim_nor_erase_seq;
  localparam int NSECT = 16;
  localparam int IW    = 4;
  localparam int AW    = 22;
  localparam int SHW   = 5;
  localparam int TW    = 16;
  localparam int WCYC  = 16;
  localparam logic [21:0] BASE = 22'h100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [IW:0] first_sect = '0, last_sect = '0;
  logic [NSECT-1:0] protect = '0;
  logic [SHW-1:0] sect_shift = '0;
  logic [TW-1:0] tout_cycles = '0;
  logic busy, done, req, we, ack;
  logic [1:0] status;
  logic [IW:0] skipped;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata;

  always #2.5 clk = ~clk;

  nor_erase_seq #(.NSECT(NSECT), .AW(AW), .SHW(SHW), .TW(TW),
                  .WAIT_CYC(WCYC), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst(rst), .start(start), .first_sect(first_sect),
    .last_sect(last_sect), .protect(protect), .sect_shift(sect_shift),
    .tout_cycles(tout_cycles), .busy(busy), .done(done), .status(status),
    .skipped(skipped), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata));

  int errors = 0, checks = 0, cyc = 0;
  int n_log = 0, n_reads = 0, ready_after = 0;
  logic [AW-1:0] l_addr [64];
  logic [7:0]    l_data [64];
  logic          l_we   [64];
  int            l_cyc  [64];
  int done_cyc;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0; rdata <= 8'h00;
    end else if (req && !ack) begin
      ack <= 1'b1;
      if (n_log < 64) begin
        l_addr[n_log] <= addr; l_data[n_log] <= wdata;
        l_we[n_log] <= we; l_cyc[n_log] <= cyc;
      end
      n_log <= n_log + 1;
      if (!we) begin
        rdata <= (n_reads >= ready_after) ? 8'h80 : 8'h00;
        n_reads <= n_reads + 1;
      end
    end else begin
      ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic run_op(input int f, input int l, input logic [NSECT-1:0] p,
                        input int sh, input int tout, input int rdy, input bit extra);
    int guard = 0;
    @(negedge clk);
    n_log = 0; n_reads = 0; ready_after = rdy;
    first_sect = (IW+1)'(f); last_sect = (IW+1)'(l);
    protect = p; sect_shift = SHW'(sh); tout_cycles = TW'(tout);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (extra && guard == 6) begin
        // R11: pulse with an invalid range while busy
        first_sect = 5'd9; last_sect = 5'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first_sect = (IW+1)'(f); last_sect = (IW+1)'(l);
      end
    end
    done_cyc = cyc;
    chk(done, "done_seen", done, 1);
    @(negedge clk);
    chk(!done && !busy, "R9 done_one_cycle", {done, busy}, 0);
  endtask

  task automatic verify(input int f, input int l, input logic [NSECT-1:0] p,
                        input int sh, input int tout, input int rdy, input bit expect_tout);
    logic [AW-1:0] soff [5] = '{22'h555, 22'h2AA, 22'h555, 22'h555, 22'h2AA};
    logic [7:0]    sdat [5] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55};
    int k = 0, skip = 0, last_s = -1, last_er = 0;
    for (int i = 0; i < 5; i++) begin
      chk(l_we[k] && l_addr[k] == BASE + soff[i] && l_data[k] == sdat[i],
          "R2 setup", {l_addr[k], l_data[k]}, {BASE + soff[i], sdat[i]});
      k++;
    end
    for (int s = f; s <= l; s++) begin
      if (p[s]) skip++;
      else begin
        chk(l_we[k] && l_addr[k] == BASE + (AW'(s) << sh) && l_data[k] == 8'h30,
            "R3 sector_cmd", {l_addr[k], l_data[k]}, {BASE + (AW'(s) << sh), 8'h30});
        last_s = s; last_er = l_cyc[k]; k++;
      end
    end
    chk(skipped == (IW+1)'(skip), "R4 skipped", skipped, skip);
    if (last_s < 0) begin
      chk(n_log == k + 1, "R8 no_poll", n_log, k + 1);
    end else begin
      chk(!l_we[k] && l_cyc[k] - last_er >= WCYC, "R5 settle_gap", l_cyc[k] - last_er, WCYC);
      if (expect_tout) begin
        int r = 0;
        for (int j = k; j < n_log; j++) if (!l_we[j] && l_addr[j] == BASE + (AW'(last_s) << sh)) r++;
        chk(r == n_log - k && r > 0, "R7 only_reads", r, n_log - k);
        chk(status == 2'd1, "R7 status", status, 1);
        chk(done_cyc - l_cyc[k] >= tout - 4, "R7 not_early", done_cyc - l_cyc[k], tout);
        return;
      end
      for (int j = 0; j <= rdy; j++) begin
        chk(!l_we[k] && l_addr[k] == BASE + (AW'(last_s) << sh), "R6 poll_addr",
            l_addr[k], BASE + (AW'(last_s) << sh));
        k++;
      end
      chk(n_log == k + 1, "R6 poll_count", n_log, k + 1);
    end
    chk(l_we[k] && l_addr[k] == AW'(BASE) && l_data[k] == 8'hF0, "R9 read_mode",
        {l_addr[k], l_data[k]}, {AW'(BASE), 8'hF0});
    chk(status == 2'd0, "R9 status", status, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !req && status == 0 && skipped == 0, "reset_state",
        {busy, done, req, status}, 0);
  endtask

  task automatic t_basic();
    run_op(2, 5, 16'h0008, 8, 200, 3, 1'b0);
    verify(2, 5, 16'h0008, 8, 200, 3, 1'b0);
  endtask

  task automatic t_pattern();
    run_op(0, 7, 16'h00AA, 4, 200, 1, 1'b0);
    verify(0, 7, 16'h00AA, 4, 200, 1, 1'b0);
  endtask

  task automatic t_all_prot();
    run_op(0, 3, 16'h000F, 8, 200, 0, 1'b0);
    verify(0, 3, 16'h000F, 8, 200, 0, 1'b0);
  endtask

  task automatic t_top_sector();
    run_op(15, 15, 16'h0000, 12, 200, 0, 1'b0);
    verify(15, 15, 16'h0000, 12, 200, 0, 1'b0);
  endtask

  task automatic t_bad(input int f, input int l, input string tag);
    run_op(f, l, 16'h0000, 8, 200, 0, 1'b0);
    chk(status == 2'd2, {"R1 status ", tag}, status, 2);
    chk(n_log == 0, {"R1 no_bus ", tag}, n_log, 0);
    chk(skipped == 0, {"R1 skipped ", tag}, skipped, 0);
  endtask

  task automatic t_timeout();
    run_op(1, 2, 16'h0000, 8, 40, 1000, 1'b0);
    verify(1, 2, 16'h0000, 8, 40, 1000, 1'b1);
  endtask

  task automatic t_busy_start();
    run_op(3, 6, 16'h0010, 8, 200, 2, 1'b1);
    verify(3, 6, 16'h0010, 8, 200, 2, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pattern();
    t_all_prot();
    t_top_sector();
    t_bad(5, 2, "first_gt_last");
    t_bad(-1, 3, "neg_first");
    t_bad(2, 16, "last_oob");
    t_timeout();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule